// File: doc/BRIEF.md
# Key-Guarded Configuration Register Unit

This unit holds a handful of configuration words that drive control signals into the rest of a chip. Software reaches it over a plain register bus with a write strobe, a read strobe, a word offset, write data and registered read data. One word is open: a single bus write changes it. A second word sits behind a gate register. Writing the correct key to the gate opens a write window that is only a few cycles long and then closes by itself. A third word sits behind two kick registers, and it can only be written while both kick registers hold their keys.

Some bits in the open word and in the kick-guarded word are write-once. A write can set them, but a write of zero leaves them set. Only reset clears them. A write to a guarded word while its guard is closed is dropped, and it raises a sticky violation flag. Software clears that flag by writing 1 to the status word. Keys cannot be read back, because the gate and kick registers always return zero.

Offsets (3-bit word address): 0 open word, 1 gated word, 2 gate, 3 kick-guarded word, 4 kick A, 5 kick B, 6 status (bit 0 = violation flag), 7 unused.

Top module: `keylock_cfg_unit`

## Requirements
- R1: A write to offset 0 updates `cfg_open` at the next clock edge without any key. A read strobe returns the addressed word on `rdata` one cycle later. Reads of offset 7 return zero.
- R2: A write to offset 1 is accepted only while the gate window is open. Outside the window `cfg_guard` keeps its value.
- R3: Writing GATE_KEY to offset 2 opens the window for exactly WINDOW cycles (default 4), counted from the cycle after the key write. A gated write in cycle key+WINDOW is accepted. A gated write in cycle key+WINDOW+1 is refused.
- R4: Any gate write whose value differs from GATE_KEY (zero included) closes the window at once. An accepted gated write also closes it.
- R5: A write to offset 3 is accepted only while kick A holds KICK_KEY0 and kick B holds KICK_KEY1. One key alone is not enough, and access stays open for repeated writes while both keys are held.
- R6: Writing zero (or any non-key value) to a kick register closes the kick-guarded word again.
- R7: Bits set in OPEN_WO (default bits 7:0 of offset 0) and DUAL_WO (default bits 3:0 of offset 3) are write-once. A write of 1 sets them and a write of 0 leaves them set. All other bits follow the written data.
- R8: A refused write to offset 1 or 3 sets `viol` and status bit 0, and the flag stays set. Writing 1 to status bit 0 clears it. Writing 0 to it has no effect.
- R9: Reads of offsets 2, 4 and 5 always return zero, even while keys are held.
- R10: While `rst_n` is low at a clock edge, all configuration words, `viol`, `rdata`, the window and both kick keys are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cfg_open | output | DATA_W | Contents of the open word |
| cfg_guard | output | DATA_W | Contents of the gated word |
| cfg_dual | output | DATA_W | Contents of the kick-guarded word |
| viol | output | 1 | Sticky violation flag |

## Verification
The assertions check these rules on every cycle:
- The gate window never stays open longer than WINDOW cycles after a key write.
- A refused write leaves its word unchanged and raises `viol`.
- Write-once bits never fall outside reset.
- Gate and kick reads return zero.
- Reset clears the outputs.

Other behaviour needs the bench's directed sequences, checked against its behavioural model. These sequences cover:
- the exact last accepted cycle of the window;
- early closing by a zero key, a wrong key or an accepted write;
- the need for both kick keys;
- repeated writes while the kick keys are held;
- the clear-by-one rule of the status flag.

// File: rtl/keylock_pkg.sv
// Package: register offsets and the decoded write-select type shared by
// the configuration unit and its checker. Assumes a word address of at
// least three bits.
package keylock_pkg;

    localparam int unsigned OFF_OPEN  = 0;
    localparam int unsigned OFF_GUARD = 1;
    localparam int unsigned OFF_GATE  = 2;
    localparam int unsigned OFF_DUAL  = 3;
    localparam int unsigned OFF_KICKA = 4;
    localparam int unsigned OFF_KICKB = 5;
    localparam int unsigned OFF_STAT  = 6;
    localparam int unsigned NUM_KICK  = 2;

    typedef struct packed {
        logic open;
        logic guard;
        logic gate;
        logic dual;
        logic kicka;
        logic kickb;
        logic stat;
    } wr_sel_t;

endpackage

// File: rtl/keylock_gate.sv
// Module: single-key gate with a self-closing window.
// A matching key write loads the window counter with WINDOW. The window is
// open while the counter is non-zero, and the counter steps down once per
// cycle. A non-matching key write or a consumed write empties it at once.
// Assumes key_wr and use_i are never high in the same cycle.
module keylock_gate #(
    parameter int          DATA_W = 32,
    parameter int          WINDOW = 4,
    parameter logic [31:0] KEY    = 32'hA5C3_0F1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              use_i,
    output logic              open_o
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LOAD = CW'(WINDOW);

    logic [CW-1:0] remain;

    // Window counter: load on a key write, clear on a mismatch or a consumed write, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (key_wr) begin
            remain <= (key_data == KEY[DATA_W-1:0]) ? LOAD : '0;
        end else if (use_i) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Window state as seen by the write path.
    always_comb begin
        open_o = (remain != '0);
    end
endmodule

// File: rtl/keylock_kick.sv
// Module: one kick register. It holds only a "key present" flag, never the
// written value, so the key cannot be read back. Each write re-evaluates
// the flag.
module keylock_kick #(
    parameter int          DATA_W = 32,
    parameter logic [31:0] KEY    = 32'h1357_9BDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    output logic              held_o
);
    // Key-present flag: set by a matching write, cleared by any other write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= 1'b0;
        end else if (wr) begin
            held_o <= (data == KEY[DATA_W-1:0]);
        end
    end
endmodule

// File: rtl/keylock_cfgreg.sv
// Module: one configuration word with write-once bits.
// Bits in WO_MASK can only be set by a write. The other bits take the
// written value. Assumes that the caller has already applied any access guard
// to we.
module keylock_cfgreg #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] WO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] next_q;

    // Merge the written data with the write-once bits.
    always_comb begin
        next_q = (wdata & ~WO_MASK) | ((q | wdata) & WO_MASK);
    end

    // Storage for the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= next_q;
        end
    end
endmodule

// File: rtl/keylock_cfg_unit.sv
// Module: top of the key-guarded configuration unit.
// It decodes bus writes, applies the gate and kick guards, raises the sticky
// violation flag on refused writes and returns registered read data.
// Assumes at most one bus access per cycle, with ADDR_W >= 3 and
// DATA_W <= 32 for the keys.
module keylock_cfg_unit
    import keylock_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 3,
    parameter int                WINDOW    = 4,
    parameter logic [31:0]       GATE_KEY  = 32'hA5C3_0F1E,
    parameter logic [31:0]       KICK_KEY0 = 32'h1357_9BDF,
    parameter logic [31:0]       KICK_KEY1 = 32'h2468_ACE0,
    parameter logic [DATA_W-1:0] OPEN_WO   = DATA_W'(32'h0000_00FF),
    parameter logic [DATA_W-1:0] GUARD_WO  = '0,
    parameter logic [DATA_W-1:0] DUAL_WO   = DATA_W'(32'h0000_000F)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] cfg_open,
    output logic [DATA_W-1:0] cfg_guard,
    output logic [DATA_W-1:0] cfg_dual,
    output logic              viol
);
    wr_sel_t             sel;
    logic                gate_open;
    logic [NUM_KICK-1:0] kick_held;
    logic                kick_both;
    logic                guard_we;
    logic                dual_we;
    logic                refuse;
    logic [DATA_W-1:0]   rd_mux;

    // Decode the write strobe into one select per register.
    always_comb begin
        sel       = '0;
        sel.open  = wr_en && (addr == ADDR_W'(OFF_OPEN));
        sel.guard = wr_en && (addr == ADDR_W'(OFF_GUARD));
        sel.gate  = wr_en && (addr == ADDR_W'(OFF_GATE));
        sel.dual  = wr_en && (addr == ADDR_W'(OFF_DUAL));
        sel.kicka = wr_en && (addr == ADDR_W'(OFF_KICKA));
        sel.kickb = wr_en && (addr == ADDR_W'(OFF_KICKB));
        sel.stat  = wr_en && (addr == ADDR_W'(OFF_STAT));
    end

    keylock_gate #(
        .DATA_W (DATA_W),
        .WINDOW (WINDOW),
        .KEY    (GATE_KEY)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (sel.gate),
        .key_data (wdata),
        .use_i    (guard_we),
        .open_o   (gate_open)
    );

    // One kick register per key, selected by index.
    for (genvar gi = 0; gi < NUM_KICK; gi++) begin : g_kick
        localparam logic [31:0] K = (gi == 0) ? KICK_KEY0 : KICK_KEY1;
        logic kwr;
        assign kwr = (gi == 0) ? sel.kicka : sel.kickb;
        keylock_kick #(
            .DATA_W (DATA_W),
            .KEY    (K)
        ) u_kick (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (kwr),
            .data   (wdata),
            .held_o (kick_held[gi])
        );
    end

    // Apply the guards and flag any refused write.
    always_comb begin
        kick_both = &kick_held;
        guard_we  = sel.guard && gate_open;
        dual_we   = sel.dual && kick_both;
        refuse    = (sel.guard && !gate_open) || (sel.dual && !kick_both);
    end

    keylock_cfgreg #(.DATA_W(DATA_W), .WO_MASK(OPEN_WO)) u_open (
        .clk(clk), .rst_n(rst_n), .we(sel.open), .wdata(wdata), .q(cfg_open)
    );
    keylock_cfgreg #(.DATA_W(DATA_W), .WO_MASK(GUARD_WO)) u_guard (
        .clk(clk), .rst_n(rst_n), .we(guard_we), .wdata(wdata), .q(cfg_guard)
    );
    keylock_cfgreg #(.DATA_W(DATA_W), .WO_MASK(DUAL_WO)) u_dual (
        .clk(clk), .rst_n(rst_n), .we(dual_we), .wdata(wdata), .q(cfg_dual)
    );

    // Sticky violation flag: set by a refusal, cleared by writing 1 to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= 1'b0;
        end else if (refuse) begin
            viol <= 1'b1;
        end else if (sel.stat && wdata[0]) begin
            viol <= 1'b0;
        end
    end

    // Read selection. Gate, kick and unused offsets return zero.
    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(OFF_OPEN)) begin
            rd_mux = cfg_open;
        end else if (addr == ADDR_W'(OFF_GUARD)) begin
            rd_mux = cfg_guard;
        end else if (addr == ADDR_W'(OFF_DUAL)) begin
            rd_mux = cfg_dual;
        end else if (addr == ADDR_W'(OFF_STAT)) begin
            rd_mux = {{(DATA_W-1){1'b0}}, viol};
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/keylock_cfg_unit_chk.sv
// Module: assertion checker for keylock_cfg_unit, attached with bind.
// Assumes a reset held for at least two cycles before the first access.
module keylock_cfg_unit_chk
    import keylock_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                ADDR_W  = 3,
    parameter int                WINDOW  = 4,
    parameter logic [DATA_W-1:0] OPEN_WO = '0,
    parameter logic [DATA_W-1:0] DUAL_WO = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] cfg_open,
    input logic [DATA_W-1:0] cfg_guard,
    input logic [DATA_W-1:0] cfg_dual,
    input logic              viol,
    input logic              gate_open,
    input logic              kick_both
);
    logic [15:0] open_run;
    logic        key_wr;
    logic        guard_wr;
    logic        dual_wr;
    logic        hidden_rd;

    // Classify the bus access of the current cycle.
    always_comb begin
        key_wr    = wr_en && (addr == ADDR_W'(OFF_GATE));
        guard_wr  = wr_en && (addr == ADDR_W'(OFF_GUARD));
        dual_wr   = wr_en && (addr == ADDR_W'(OFF_DUAL));
        hidden_rd = rd_en && ((addr == ADDR_W'(OFF_GATE)) ||
                              (addr == ADDR_W'(OFF_KICKA)) ||
                              (addr == ADDR_W'(OFF_KICKB)));
    end

    // Count the open cycles of the gate since the last key write.
    always_ff @(posedge clk) begin
        if (!rst_n || key_wr || !gate_open) begin
            open_run <= '0;
        end else if (open_run != 16'hFFFF) begin
            open_run <= open_run + 1'b1;
        end
    end

    a_r3_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> (open_run < 16'(WINDOW)));

    a_r2_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_wr && !gate_open) |=> $stable(cfg_guard));

    a_r5_dual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_wr && !kick_both) |=> $stable(cfg_dual));

    a_r8_viol_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((guard_wr && !gate_open) || (dual_wr && !kick_both)) |=> viol);

    a_r7_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_open & OPEN_WO) != '0) |=>
            ((cfg_open & $past(cfg_open) & OPEN_WO) == ($past(cfg_open) & OPEN_WO)));

    a_r7_dual_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_dual & DUAL_WO) != '0) |=>
            ((cfg_dual & $past(cfg_dual) & DUAL_WO) == ($past(cfg_dual) & DUAL_WO)));

    a_r9_keys_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        hidden_rd |=> (rdata == '0));

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cfg_open == '0 && cfg_guard == '0 && cfg_dual == '0 && !viol));
endmodule

bind keylock_cfg_unit keylock_cfg_unit_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .WINDOW  (WINDOW),
    .OPEN_WO (OPEN_WO),
    .DUAL_WO (DUAL_WO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .cfg_open  (cfg_open),
    .cfg_guard (cfg_guard),
    .cfg_dual  (cfg_dual),
    .viol      (viol),
    .gate_open (gate_open),
    .kick_both (kick_both)
);

// File: tb/keylock_cfg_unit_bench.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks with expected constants taken from the requirements.
module keylock_cfg_unit_bench;
    localparam logic [31:0] GKEY = 32'hA5C3_0F1E;
    localparam logic [31:0] KA   = 32'h1357_9BDF;
    localparam logic [31:0] KB   = 32'h2468_ACE0;
    localparam logic [31:0] OWO  = 32'h0000_00FF;
    localparam logic [31:0] DWO  = 32'h0000_000F;
    localparam int          WIN  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, cfg_open, cfg_guard, cfg_dual;
    logic        viol;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    live = 0;
    string phase = "R10";

    // reference model state
    logic [31:0] m_open = '0, m_guard = '0, m_dual = '0, m_rd = '0;
    logic        m_err = 0, m_ka = 0, m_kb = 0;
    int          m_win = 0;

    keylock_cfg_unit u_keylock_cfg_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cfg_open(cfg_open), .cfg_guard(cfg_guard),
        .cfg_dual(cfg_dual), .viol(viol)
    );

    always #5 clk = ~clk;

    // Model update at each rising edge from the requirements.
    always @(posedge clk) begin
        live <= 1;
        if (!rst_n) begin
            m_open = '0; m_guard = '0; m_dual = '0; m_rd = '0;
            m_err = 0; m_ka = 0; m_kb = 0; m_win = 0;
        end else begin
            if (rd_en) begin
                case (addr)
                    3'd0: m_rd = m_open;
                    3'd1: m_rd = m_guard;
                    3'd3: m_rd = m_dual;
                    3'd6: m_rd = {31'd0, m_err};
                    default: m_rd = '0;
                endcase
            end
            if (wr_en && addr == 3'd2) begin
                m_win = (wdata == GKEY) ? WIN : 0;
            end else if (wr_en && addr == 3'd1) begin
                if (m_win > 0) begin m_guard = wdata; m_win = 0; end
                else m_err = 1;
            end else if (m_win > 0) begin
                m_win = m_win - 1;
            end
            if (wr_en) begin
                case (addr)
                    3'd0: m_open = (wdata & ~OWO) | ((m_open | wdata) & OWO);
                    3'd3: if (m_ka && m_kb) m_dual = (wdata & ~DWO) | ((m_dual | wdata) & DWO);
                          else m_err = 1;
                    3'd4: m_ka = (wdata == KA);
                    3'd5: m_kb = (wdata == KB);
                    3'd6: if (wdata[0]) m_err = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (live && !done) begin
            chk({phase, " open"},  cfg_open,  m_open);
            chk({phase, " guard"}, cfg_guard, m_guard);
            chk({phase, " dual"},  cfg_dual,  m_dual);
            chk({phase, " viol"},  {31'd0, viol}, {31'd0, m_err});
            chk({phase, " rdata"}, rdata, m_rd);
        end
    end

    task automatic cyc(bit w, bit r, logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
    endtask
    task automatic wr(logic [2:0] a, logic [31:0] d); cyc(1, 0, a, d); endtask
    task automatic rd(logic [2:0] a); cyc(0, 1, a, '0); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle(1);
        // R10 reset state
        chk("R10 reset open", cfg_open, 32'h0);
        chk("R10 reset viol", {31'd0, viol}, 32'h0);
        @(negedge clk); rst_n = 1;

        phase = "R1";
        wr(3'd0, 32'h1234_56A5); rd(3'd0); idle(1);
        chk("R1 open write", cfg_open, 32'h1234_56A5);
        chk("R1 readback", rdata, 32'h1234_56A5);
        rd(3'd7); idle(1);
        chk("R1 unused reads zero", rdata, 32'h0);

        phase = "R7";
        wr(3'd0, 32'h0); idle(1);
        chk("R7 write-once kept", cfg_open, 32'h0000_00A5);
        wr(3'd0, 32'hFF00_005A); idle(1);
        chk("R7 write-once set", cfg_open, 32'hFF00_00FF);

        phase = "R8";
        wr(3'd1, 32'hDEAD_BEEF); idle(1);
        chk("R2 closed gate refuses", cfg_guard, 32'h0);
        chk("R8 viol raised", {31'd0, viol}, 32'h1);
        wr(3'd6, 32'h0); rd(3'd6); idle(1);
        chk("R8 write 0 keeps flag", rdata, 32'h1);
        wr(3'd6, 32'h1); idle(1);
        chk("R8 write 1 clears flag", {31'd0, viol}, 32'h0);

        phase = "R3";
        wr(3'd2, GKEY); idle(3); wr(3'd1, 32'h0000_1111); idle(1);
        chk("R3 last window cycle accepted", cfg_guard, 32'h0000_1111);
        chk("R3 no violation", {31'd0, viol}, 32'h0);
        wr(3'd2, GKEY); idle(4); wr(3'd1, 32'h0000_2222); idle(1);
        chk("R3 after window refused", cfg_guard, 32'h0000_1111);
        chk("R3 viol after window", {31'd0, viol}, 32'h1);
        wr(3'd6, 32'h1);

        phase = "R4";
        wr(3'd2, GKEY); wr(3'd2, 32'h0); wr(3'd1, 32'h0000_3333); idle(1);
        chk("R4 zero relocks", cfg_guard, 32'h0000_1111);
        wr(3'd6, 32'h1);
        wr(3'd2, GKEY); wr(3'd1, 32'h0000_4444); wr(3'd1, 32'h0000_5555); idle(1);
        chk("R4 used window closes", cfg_guard, 32'h0000_4444);
        wr(3'd6, 32'h1);
        wr(3'd2, GKEY ^ 32'h1); wr(3'd1, 32'h0000_6666); idle(1);
        chk("R4 wrong key refused", cfg_guard, 32'h0000_4444);
        wr(3'd6, 32'h1);

        phase = "R5";
        wr(3'd4, KA); wr(3'd3, 32'hF0F0_F0F5); idle(1);
        chk("R5 single kick refused", cfg_dual, 32'h0);
        wr(3'd6, 32'h1);
        wr(3'd5, KB); wr(3'd3, 32'hF0F0_F0F5); idle(1);
        chk("R5 both kicks accept", cfg_dual, 32'hF0F0_F0F5);
        wr(3'd3, 32'h0); idle(1);
        chk("R5 repeat write / R7 dual nibble kept", cfg_dual, 32'h0000_0005);

        phase = "R9";
        rd(3'd2); idle(1); chk("R9 gate reads zero", rdata, 32'h0);
        rd(3'd4); idle(1); chk("R9 kick A reads zero", rdata, 32'h0);
        rd(3'd5); idle(1); chk("R9 kick B reads zero", rdata, 32'h0);

        phase = "R6";
        wr(3'd4, 32'h0); wr(3'd3, 32'h0000_0A00); idle(1);
        chk("R6 kick cleared refuses", cfg_dual, 32'h0000_0005);
        chk("R6 viol", {31'd0, viol}, 32'h1);

        phase = "R10";
        wr(3'd2, GKEY);
        @(negedge clk); wr_en = 0; rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R10 mid reset open", cfg_open, 32'h0);
        chk("R10 mid reset dual", cfg_dual, 32'h0);
        wr(3'd1, 32'h0000_7777); idle(1);
        chk("R10 window closed by reset", cfg_guard, 32'h0);
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule